// File: doc/BRIEF.md
# Write Ordering Enforcement Controller

This block sits between the store pipeline and the data cache and decides, every cycle, whether the write at the head of the queue may be committed. A write that hits a Modified or Exclusive line may be held back. The block holds it so that cache updates stay ordered behind writes that are still draining to the system bus. A write that hits a Shared or Invalid line is never held. It is passed on as an external write.

Two control bits choose how strict the ordering is. With the global-disable bit set, nothing is held and the external buffer-empty signal is ignored. With only the speculative-disable bit set, write-back writes to Modified or Exclusive lines wait while the external buffer reports not-empty. Uncacheable and write-combining writes are exempt from this wait. With both bits clear, which is the state after reset, a flush of the merge buffer onto the bus arms a pending flag. Modified or Exclusive commits then wait until the buffer is seen empty.

The external buffer-empty input is active low and asynchronous. It is synchronized through a register chain before any decision uses it.

Top module: `wrord_ctrl`

## Requirements
- R1: After reset the mode is fully ordered (both control bits 0) and no flush is pending, so a write hitting a Modified line is accepted at once.
- R2: While `ord_ctl[1]` (global disable) is 1, every write is accepted whatever the values of `wbe_n`, `ord_ctl[0]`, memory type and line state.
- R3: With `ord_ctl` = 2'b01, a write of memory type write-back (`req_mtype` = 0) hitting an Exclusive (`req_lstate` = 2) or Modified (`req_lstate` = 3) line is stalled (`req_ready` = 0) while the synchronized `wbe_n` is 1. It is accepted once the synchronized `wbe_n` is 0.
- R4: With `ord_ctl` = 2'b01, writes of memory type write-combining (`req_mtype` = 1) or uncacheable (`req_mtype` = 2) are never stalled.
- R5: With `ord_ctl` = 2'b00, a `mbuf_flush` pulse sets a pending flag on the next clock edge. From then on, Modified and Exclusive writes stall until the synchronized `wbe_n` has been 0 at one clock edge. This is three edges after `wbe_n` falls.
- R6: With `ord_ctl` = 2'b00 and no pending flush, `wbe_n` = 1 does not stall any write.
- R7: Writes hitting Invalid (`req_lstate` = 0) or Shared (`req_lstate` = 1) lines are never stalled. An accepted one raises `ext_write`, and an accepted Modified or Exclusive write raises `commit_grant`. The two outputs are never high together.
- R8: A new `ord_ctl` value affects `req_ready` after one clock edge. A cycle spent with the global-disable bit at 1 clears a pending flush.
- R9: `wbe_n` passes through two flip-flops, so a change reaches `req_ready` in speculative mode two clock edges after it is applied.
- R10: While `req_valid` is 1 and `req_ready` is 0, the request fields stay stable for as long as `req_valid` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ord_ctl | input | 2 | [1] global ordering disable, [0] speculative disable |
| wbe_n | input | 1 | External write buffer empty, active low, asynchronous |
| mbuf_flush | input | 1 | One-cycle pulse: merge buffer written to the bus |
| req_valid | input | 1 | Write request present |
| req_mtype | input | 2 | Memory type: 0 write-back, 1 write-combining, 2 uncacheable, 3 treated as write-back |
| req_lstate | input | 2 | Hit line state: 0 Invalid, 1 Shared, 2 Exclusive, 3 Modified |
| req_ready | output | 1 | Request accepted this cycle (0 = stall) |
| commit_grant | output | 1 | Accepted write commits to a Modified or Exclusive line |
| ext_write | output | 1 | Accepted write goes out as an external write |

## Verification
A stuck or wrongly set pending flag shows as a `req_ready` that stays low, or rises early, on Modified or Exclusive writes in the fully ordered mode. It appears within one cycle of the flush or of the third edge after `wbe_n` falls. A synchronizer of the wrong depth moves the speculative-mode release by one edge, and the bench checks that release at each edge. A mode register that is bypassed or missing shows as `req_ready` changing in the same cycle as `ord_ctl`.

// File: rtl/wrord_pkg.sv
package wrord_pkg;
    localparam int CTL_W = 2;
    localparam int MT_W  = 2;
    localparam int LS_W  = 2;

    localparam logic [MT_W-1:0] MT_WB = 2'd0;
    localparam logic [MT_W-1:0] MT_WC = 2'd1;
    localparam logic [MT_W-1:0] MT_UC = 2'd2;

    localparam logic [LS_W-1:0] LS_I = 2'd0;
    localparam logic [LS_W-1:0] LS_S = 2'd1;
    localparam logic [LS_W-1:0] LS_E = 2'd2;
    localparam logic [LS_W-1:0] LS_M = 2'd3;

    localparam logic [CTL_W-1:0] MODE_ORDERED = 2'b00;
    localparam logic [CTL_W-1:0] MODE_SPEC    = 2'b01;

    typedef struct packed {
        logic [CTL_W-1:0] mode;
        logic             pend;
    } ord_state_t;
endpackage

// File: rtl/wrord_sync.sv
module wrord_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], async_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= {STAGES{RST_VAL}};
        else        sh_q <= sh_d;
    end

    assign sync_out = sh_q[STAGES-1];
endmodule

// File: rtl/wrord_state.sv
module wrord_state
    import wrord_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CTL_W-1:0] ctl_in,
    input  logic             flush,
    input  logic             empty_s,
    output logic [CTL_W-1:0] mode_q,
    output logic             pend_q
);
    ord_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.mode = ctl_in;
        if (st_q.mode[1]) begin
            st_d.pend = 1'b0;
        end else if (st_q.mode == MODE_ORDERED && flush) begin
            st_d.pend = 1'b1;
        end else if (empty_s) begin
            st_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{mode: MODE_ORDERED, pend: 1'b0};
        else        st_q <= st_d;
    end

    assign mode_q = st_q.mode;
    assign pend_q = st_q.pend;

    assert_flush_sets_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_ORDERED && flush) |=> pend_q);

    assert_global_clears_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q[1] |=> !pend_q);
endmodule

// File: rtl/wrord_decide.sv
module wrord_decide
    import wrord_pkg::*;
(
    input  logic [CTL_W-1:0] mode,
    input  logic             pend,
    input  logic             empty_s,
    input  logic             req_valid,
    input  logic [MT_W-1:0]  req_mtype,
    input  logic [LS_W-1:0]  req_lstate,
    output logic             req_ready,
    output logic             commit_grant,
    output logic             ext_write
);
    logic owned;
    logic exempt;
    logic hold;

    always_comb begin
        owned  = (req_lstate == LS_M) || (req_lstate == LS_E);
        exempt = (req_mtype == MT_UC) || (req_mtype == MT_WC);
        hold   = 1'b0;
        if (mode[1]) begin
            hold = 1'b0;
        end else if (mode == MODE_SPEC) begin
            hold = owned && !exempt && !empty_s;
        end else begin
            hold = owned && pend;
        end
        req_ready    = !hold;
        commit_grant = req_valid && !hold && owned;
        ext_write    = req_valid && !hold && !owned;
    end
endmodule

// File: rtl/wrord_ctrl.sv
module wrord_ctrl
    import wrord_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CTL_W-1:0] ord_ctl,
    input  logic             wbe_n,
    input  logic             mbuf_flush,
    input  logic             req_valid,
    input  logic [MT_W-1:0]  req_mtype,
    input  logic [LS_W-1:0]  req_lstate,
    output logic             req_ready,
    output logic             commit_grant,
    output logic             ext_write
);
    logic             wbe_n_s;
    logic             empty_s;
    logic [CTL_W-1:0] mode_q;
    logic             pend_q;

    wrord_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (wbe_n),
        .sync_out (wbe_n_s)
    );

    assign empty_s = !wbe_n_s;

    wrord_state u_state (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctl_in  (ord_ctl),
        .flush   (mbuf_flush),
        .empty_s (empty_s),
        .mode_q  (mode_q),
        .pend_q  (pend_q)
    );

    wrord_decide u_decide (
        .mode         (mode_q),
        .pend         (pend_q),
        .empty_s      (empty_s),
        .req_valid    (req_valid),
        .req_mtype    (req_mtype),
        .req_lstate   (req_lstate),
        .req_ready    (req_ready),
        .commit_grant (commit_grant),
        .ext_write    (ext_write)
    );

    assert_global_never_stalls_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ord_ctl[1] |=> req_ready);

    assert_shared_invalid_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_lstate == LS_S || req_lstate == LS_I)) |-> (req_ready && ext_write));

    assert_outputs_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({commit_grant, ext_write}));

    assert_fields_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=>
            (!req_valid || ($stable(req_mtype) && $stable(req_lstate))));
endmodule

// File: tb/wrord_ctrl_bench.sv
`timescale 1ns/1ps
module wrord_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] ord_ctl = 2'b00;
    logic       wbe_n = 1'b1;
    logic       mbuf_flush = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_mtype = 2'd0;
    logic [1:0] req_lstate = 2'd0;
    logic       req_ready, commit_grant, ext_write;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    wrord_ctrl u_wrord_ctrl (
        .clk(clk), .rst_n(rst_n), .ord_ctl(ord_ctl), .wbe_n(wbe_n),
        .mbuf_flush(mbuf_flush), .req_valid(req_valid), .req_mtype(req_mtype),
        .req_lstate(req_lstate), .req_ready(req_ready),
        .commit_grant(commit_grant), .ext_write(ext_write)
    );

    // {ctl[1:0], wbe_n, mtype[1:0], lstate[1:0], ready, grant, ext}
    localparam int NV = 12;
    localparam logic [9:0] VEC [NV] = '{
        {2'b00, 1'b1, 2'd0, 2'd3, 3'b110},  // R6
        {2'b00, 1'b1, 2'd0, 2'd1, 3'b101},  // R7
        {2'b01, 1'b1, 2'd0, 2'd3, 3'b000},  // R3
        {2'b01, 1'b1, 2'd0, 2'd2, 3'b000},  // R3
        {2'b01, 1'b0, 2'd0, 2'd3, 3'b110},  // R3
        {2'b01, 1'b1, 2'd2, 2'd3, 3'b110},  // R4
        {2'b01, 1'b1, 2'd1, 2'd2, 3'b110},  // R4
        {2'b01, 1'b1, 2'd0, 2'd0, 3'b101},  // R7
        {2'b10, 1'b1, 2'd0, 2'd3, 3'b110},  // R2
        {2'b11, 1'b1, 2'd0, 2'd2, 3'b110},  // R2
        {2'b11, 1'b0, 2'd0, 2'd1, 3'b101},  // R2
        {2'b00, 1'b0, 2'd0, 2'd2, 3'b110}   // R6
    };
    localparam string TAG [NV] = '{"R6","R7","R3","R3","R3","R4","R4","R7","R2","R2","R2","R6"};

    task automatic check(input string tag, input logic [2:0] got, input logic [2:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: {ready,grant,ext} got %b expected %b", tag, got, exp);
        end
    endtask

    function automatic logic [2:0] outs();
        return {req_ready, commit_grant, ext_write};
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 20);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        req_valid = 1'b1; req_mtype = 2'd0; req_lstate = 2'd3;
        #1 check("R1", outs(), 3'b110);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;

        // table walk
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            ord_ctl = VEC[i][9:8];
            wbe_n = VEC[i][7];
            req_mtype = VEC[i][6:5];
            req_lstate = VEC[i][4:3];
            repeat (3) @(posedge clk);
            @(negedge clk);
            req_valid = 1'b1;
            #1 check(TAG[i], outs(), VEC[i][2:0]);
            @(posedge clk);
            @(negedge clk);
            req_valid = 1'b0;
        end

        // R9: synchronizer latency in speculative mode
        @(negedge clk);
        ord_ctl = 2'b01; wbe_n = 1'b1; req_mtype = 2'd0; req_lstate = 2'd3;
        repeat (3) @(posedge clk);
        @(negedge clk);
        req_valid = 1'b1;
        wbe_n = 1'b0;
        #1 check("R9 edge0", outs(), 3'b000);
        @(posedge clk); @(negedge clk);
        #1 check("R9 edge1", outs(), 3'b000);
        @(posedge clk); @(negedge clk);
        #1 check("R9 edge2", outs(), 3'b110);
        req_valid = 1'b0;

        // R5: flush arms pending in ordered mode
        @(negedge clk);
        ord_ctl = 2'b00; wbe_n = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        req_valid = 1'b1; mbuf_flush = 1'b1;
        #1 check("R5 flush cycle", outs(), 3'b110);
        @(posedge clk); @(negedge clk);
        mbuf_flush = 1'b0;
        #1 check("R5 pending stall", outs(), 3'b000);
        @(posedge clk); @(negedge clk);
        wbe_n = 1'b0;
        #1 check("R5 still stalled", outs(), 3'b000);
        @(posedge clk); @(negedge clk);
        #1 check("R5 edge1", outs(), 3'b000);
        @(posedge clk); @(negedge clk);
        #1 check("R5 edge2", outs(), 3'b000);
        @(posedge clk); @(negedge clk);
        #1 check("R5 edge3 release", outs(), 3'b110);

        // R8: mode change latency and pending clear by global mode
        wbe_n = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        mbuf_flush = 1'b1;
        @(posedge clk); @(negedge clk);
        mbuf_flush = 1'b0;
        #1 check("R8 armed", outs(), 3'b000);
        ord_ctl = 2'b10;
        #1 check("R8 no same-cycle effect", outs(), 3'b000);
        @(posedge clk); @(negedge clk);
        #1 check("R8 global after one edge", outs(), 3'b110);
        ord_ctl = 2'b00;
        @(posedge clk); @(negedge clk);
        #1 check("R8 pending cleared", outs(), 3'b110);
        req_valid = 1'b0;
        #1 check("R7 idle outputs", outs(), 3'b100);

        @(posedge clk);
        finish_run();
    end
endmodule